// File: doc/BRIEF.md
# Video Capture Frame Buffer Writer

This block sits between a video decoder's output and a synchronous SRAM frame buffer. On the capture clock it takes 10-bit luma samples and keeps only the upper eight bits. It follows the field, vertical-sync and horizontal-sync flags and a data-valid strobe to track the current column and line. It collects four pixels into one 36-bit memory word and forms that word's 19-bit frame-buffer address.

Each finished word and its address are held steady in the capture domain while a single toggle bit crosses into the memory clock domain through a flop synchronizer. On the memory side the word waits in a one-deep pending register. It is issued as a write only when the display column's low two bits, supplied by the display timing, show the write slot. If a newer word lands while one is still waiting, the newer one replaces it and a sticky overflow flag goes high. A test input swaps the luma for a column ramp, so the write path can be exercised without live video.

Top module: `vfw_writer`

## Requirements
- R1: A stored pixel is luma bits 9:2. Four consecutive counted pixels form one word: the first in bits 31:24, then 23:16, then 15:8, the last in bits 7:0. Bits 35:32 are zero.
- R2: The write address is {1'b0, row[9:0], column[9:2]}, where row = {line[8:0], field flag} and column is the index of the group's first pixel.
- R3: A sample counts as a pixel only when data-valid is 1 and both the vertical-sync and horizontal-sync flags are 0. Any other sample leaves column and packing unchanged.
- R4: Horizontal or vertical sync clears the column to 0 and discards a partly filled group. Each rising edge of horizontal sync adds one to the line. Vertical sync holds the line at 0.
- R5: wr_en is asserted only in a cycle where slot_in equals 2. Each completed word produces at most one write.
- R6: While slots keep coming, each completed word is written within 14 memory clock cycles, and words are written in the order they completed.
- R7: While a word is pending and not yet written and no newer word arrives, wr_addr and wr_data stay unchanged.
- R8: A word that arrives while an earlier word is still pending and not being written replaces it, and ovf becomes 1 and stays 1 until reset.
- R9: With test_en at 1, the pixel value is the low 8 bits of the current column instead of the luma.
- R10: Synchronous active-high resets clear the column, line, packing, toggle, pending write and ovf in their own domains. After reset, wr_en and ovf are 0 and the next word goes to row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Capture-side clock |
| cap_rst | input | 1 | Synchronous active-high reset for the capture domain |
| luma_in | input | 10 | Luma sample from the decoder |
| fld_in | input | 1 | Field flag; selects odd or even rows |
| vsync_in | input | 1 | Vertical sync flag |
| hsync_in | input | 1 | Horizontal sync flag |
| dval_in | input | 1 | Sample valid strobe |
| test_en | input | 1 | Replace luma with the column ramp |
| mem_clk | input | 1 | Memory-side clock |
| mem_rst | input | 1 | Synchronous active-high reset for the memory domain |
| slot_in | input | 2 | Low two bits of the display column |
| wr_en | output | 1 | Write request to the frame buffer |
| wr_addr | output | 19 | Frame buffer word address |
| wr_data | output | 36 | Frame buffer write word |
| ovf | output | 1 | Sticky flag: a pending word was replaced |

## Verification
The packed word and its address are registered at the capture edge that follows the fourth counted pixel. The toggle then needs two synchronizer edges and one edge-detect edge on the memory clock before the word is pending, and at most three more memory cycles until slot 2 comes round. The bench therefore does not expect a write in a fixed cycle. Instead it keeps a queue of expected words stamped with the memory cycle in which each one completed. On every memory clock it checks that any write matches the head of the queue in address and data, that it falls in slot 2, and that no entry is older than 14 cycles. During the blocked-slot phase the age limit is lifted, and the overflow flag and the surviving word are checked once slots resume.

// File: rtl/vfw_pkg.sv
package vfw_pkg;
   localparam int VFW_LUMA_W     = 10;
   localparam int VFW_PIX_W      = 8;
   localparam int VFW_PPW        = 4;
   localparam int VFW_WORD_W     = 36;
   localparam int VFW_COL_W      = 10;
   localparam int VFW_LINE_W     = 10;
   localparam int VFW_SYNC_DEPTH = 2;
   localparam int VFW_SLOT_W     = 2;
   localparam int VFW_WR_SLOT    = 2;

   function automatic int vfw_addr_w(input int line_w, input int col_w, input int ppw);
      return 1 + line_w + col_w - $clog2(ppw);
   endfunction
endpackage

// File: rtl/vfw_capture.sv
module vfw_capture #(
   parameter int LUMA_W = 10,
   parameter int PIX_W  = 8,
   parameter int PPW    = 4,
   parameter int COL_W  = 10,
   parameter int LINE_W = 10,
   parameter int ADDR_W = 19
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [LUMA_W-1:0]      luma,
   input  logic                   fld,
   input  logic                   vsy,
   input  logic                   hsy,
   input  logic                   dval,
   input  logic                   test_en,
   output logic [PIX_W*PPW-1:0]   word_q,
   output logic [ADDR_W-1:0]      addr_q,
   output logic                   tog_q,
   output logic [COL_W-1:0]       col_o
);
   localparam int GRP_W  = $clog2(PPW);
   localparam int PACK_W = PIX_W*(PPW-1);

   generate
      if (LUMA_W < PIX_W) begin : g_bad_luma
         $error("LUMA_W must be at least PIX_W");
      end
      if (COL_W < PIX_W || COL_W <= GRP_W) begin : g_bad_col
         $error("COL_W too small for pattern and grouping");
      end
      if (ADDR_W != 1 + LINE_W + COL_W - GRP_W) begin : g_bad_addr
         $error("ADDR_W does not match line and column widths");
      end
      if (PPW < 2 || (1 << GRP_W) != PPW) begin : g_bad_ppw
         $error("PPW must be a power of two of at least 2");
      end
   endgenerate

   logic [COL_W-1:0]  col_q;
   logic [LINE_W-1:0] line_q;
   logic [PACK_W-1:0] pack_q;
   logic              hs_q;
   logic [PIX_W-1:0]  pix;
   logic [LINE_W-1:0] row;
   logic              take;
   logic              last_in_grp;
   logic              unused_bits;

   assign pix         = test_en ? col_q[PIX_W-1:0] : luma[LUMA_W-1 -: PIX_W];
   assign row         = {line_q[LINE_W-2:0], fld};
   assign take        = dval && !hsy && !vsy;
   assign last_in_grp = &col_q[GRP_W-1:0];
   assign unused_bits = ^{line_q[LINE_W-1], luma[LUMA_W-PIX_W-1:0]};
   assign col_o       = col_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         col_q  <= '0;
         line_q <= '0;
         pack_q <= '0;
         hs_q   <= 1'b0;
         tog_q  <= 1'b0;
         word_q <= '0;
         addr_q <= '0;
      end else begin
         hs_q <= hsy;
         if (vsy)
            line_q <= '0;
         else if (hsy && !hs_q)
            line_q <= line_q + 1'b1;

         if (hsy || vsy) begin
            col_q  <= '0;
            pack_q <= '0;
         end else if (take) begin
            col_q <= col_q + 1'b1;
            if (last_in_grp) begin
               word_q <= {pack_q, pix};
               addr_q <= {1'b0, row, col_q[COL_W-1:GRP_W]};
               tog_q  <= ~tog_q;
               pack_q <= '0;
            end else begin
               pack_q <= PACK_W'({pack_q, pix});
            end
         end
      end
   end
endmodule

// File: rtl/vfw_xfer.sv
module vfw_xfer #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 19,
   parameter int SYNC_DEPTH = 2,
   parameter int SLOT_W     = 2,
   parameter int WR_SLOT    = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              src_tog,
   input  logic [DATA_W-1:0] src_data,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [SLOT_W-1:0] slot,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              ovf,
   output logic              pend_o,
   output logic              edge_o
);
   generate
      if (SYNC_DEPTH < 2) begin : g_bad_sync
         $error("SYNC_DEPTH must be at least 2");
      end
      if (WR_SLOT >= (1 << SLOT_W)) begin : g_bad_slot
         $error("WR_SLOT does not fit in SLOT_W bits");
      end
   endgenerate

   logic [SYNC_DEPTH-1:0] sync_q;
   logic                  last_q;
   logic                  pend_q;
   logic                  hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_DEPTH-2:0], src_tog};
         last_q <= sync_q[SYNC_DEPTH-1];
      end
   end

   assign edge_o = sync_q[SYNC_DEPTH-1] ^ last_q;
   assign hit    = pend_q && (slot == SLOT_W'(WR_SLOT));
   assign wr_en  = hit;
   assign pend_o = pend_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q  <= 1'b0;
         wr_data <= '0;
         wr_addr <= '0;
         ovf     <= 1'b0;
      end else if (edge_o) begin
         wr_data <= src_data;
         wr_addr <= src_addr;
         pend_q  <= 1'b1;
         if (pend_q && !hit)
            ovf <= 1'b1;
      end else if (hit) begin
         pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/vfw_writer.sv
module vfw_writer
   import vfw_pkg::*;
#(
   parameter int LUMA_W     = VFW_LUMA_W,
   parameter int PIX_W      = VFW_PIX_W,
   parameter int PPW        = VFW_PPW,
   parameter int WORD_W     = VFW_WORD_W,
   parameter int COL_W      = VFW_COL_W,
   parameter int LINE_W     = VFW_LINE_W,
   parameter int SYNC_DEPTH = VFW_SYNC_DEPTH,
   parameter int SLOT_W     = VFW_SLOT_W,
   parameter int WR_SLOT    = VFW_WR_SLOT,
   parameter int ADDR_W     = vfw_addr_w(VFW_LINE_W, VFW_COL_W, VFW_PPW)
) (
   input  logic              cap_clk,
   input  logic              cap_rst,
   input  logic [LUMA_W-1:0] luma_in,
   input  logic              fld_in,
   input  logic              vsync_in,
   input  logic              hsync_in,
   input  logic              dval_in,
   input  logic              test_en,
   input  logic              mem_clk,
   input  logic              mem_rst,
   input  logic [SLOT_W-1:0] slot_in,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic              ovf
);
   localparam int DATA_W = PIX_W*PPW;

   generate
      if (WORD_W < DATA_W) begin : g_bad_word
         $error("WORD_W narrower than the packed pixels");
      end
   endgenerate

   logic [DATA_W-1:0] cap_word;
   logic [ADDR_W-1:0] cap_addr;
   logic              cap_tog;
   logic [COL_W-1:0]  col_w;
   logic [DATA_W-1:0] mem_data;
   logic              pend_w;
   logic              edge_w;

   vfw_capture #(
      .LUMA_W(LUMA_W), .PIX_W(PIX_W), .PPW(PPW),
      .COL_W(COL_W), .LINE_W(LINE_W), .ADDR_W(ADDR_W)
   ) u_cap (
      .clk(cap_clk), .rst(cap_rst), .luma(luma_in), .fld(fld_in),
      .vsy(vsync_in), .hsy(hsync_in), .dval(dval_in), .test_en(test_en),
      .word_q(cap_word), .addr_q(cap_addr), .tog_q(cap_tog), .col_o(col_w)
   );

   vfw_xfer #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_DEPTH(SYNC_DEPTH),
      .SLOT_W(SLOT_W), .WR_SLOT(WR_SLOT)
   ) u_xfer (
      .clk(mem_clk), .rst(mem_rst), .src_tog(cap_tog), .src_data(cap_word),
      .src_addr(cap_addr), .slot(slot_in), .wr_en(wr_en), .wr_data(mem_data),
      .wr_addr(wr_addr), .ovf(ovf), .pend_o(pend_w), .edge_o(edge_w)
   );

   generate
      if (WORD_W > DATA_W) begin : g_pad
         assign wr_data = {{(WORD_W-DATA_W){1'b0}}, mem_data};
      end else begin : g_exact
         assign wr_data = mem_data;
      end
   endgenerate
endmodule

// File: rtl/vfw_writer_chk.sv
module vfw_writer_chk #(
   parameter int ADDR_W  = 19,
   parameter int WORD_W  = 36,
   parameter int COL_W   = 10,
   parameter int SLOT_W  = 2,
   parameter int WR_SLOT = 2
) (
   input logic              cap_clk,
   input logic              cap_rst,
   input logic              mem_clk,
   input logic              mem_rst,
   input logic              hsy,
   input logic              vsy,
   input logic [SLOT_W-1:0] slot,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [WORD_W-1:0] wr_data,
   input logic              ovf,
   input logic              pend,
   input logic              sync_edge,
   input logic [COL_W-1:0]  col
);
   // R5: writes only in the permitted slot
   assert_write_slot_R5: assert property (@(posedge mem_clk) disable iff (mem_rst)
      wr_en |-> slot == SLOT_W'(WR_SLOT));

   // R8: overflow is sticky
   assert_ovf_sticky_R8: assert property (@(posedge mem_clk) disable iff (mem_rst)
      ovf |=> ovf);

   // R7: a waiting word is held steady
   assert_pend_hold_R7: assert property (@(posedge mem_clk) disable iff (mem_rst)
      (pend && !wr_en && !sync_edge) |=> (pend && $stable(wr_addr) && $stable(wr_data)));

   // R4: sync clears the column
   assert_col_clear_R4: assert property (@(posedge cap_clk) disable iff (cap_rst)
      (hsy || vsy) |=> col == '0);
endmodule

bind vfw_writer vfw_writer_chk #(
   .ADDR_W(ADDR_W), .WORD_W(WORD_W), .COL_W(COL_W),
   .SLOT_W(SLOT_W), .WR_SLOT(WR_SLOT)
) u_chk (
   .cap_clk(cap_clk), .cap_rst(cap_rst), .mem_clk(mem_clk), .mem_rst(mem_rst),
   .hsy(hsync_in), .vsy(vsync_in), .slot(slot_in), .wr_en(wr_en),
   .wr_addr(wr_addr), .wr_data(wr_data), .ovf(ovf), .pend(pend_w),
   .sync_edge(edge_w), .col(col_w)
);

// File: tb/vfw_writer_test.sv
`timescale 1ns/1ps
module vfw_writer_test;
   logic       cclk = 1'b0, mclk = 1'b0;
   logic       crst = 1'b1, mrst = 1'b1;
   logic [9:0] luma = '0;
   logic       fld = 1'b0, vsy = 1'b0, hsy = 1'b0, dv = 1'b0, tm = 1'b0;
   logic [1:0] slot = '0;
   logic       wr_en, ovf;
   logic [18:0] wr_addr;
   logic [35:0] wr_data;

   int checks = 0, errors = 0, cyc = 0, wd = 0;
   logic block = 1'b0;
   logic [54:0] exp_q[$];
   int          t_q[$];
   string       tag = "R1";

   // model state
   int  m_col = 0, m_line = 0;
   bit  m_hprev = 0;
   logic [31:0] m_buf = '0;

   vfw_writer uut (
      .cap_clk(cclk), .cap_rst(crst), .luma_in(luma), .fld_in(fld),
      .vsync_in(vsy), .hsync_in(hsy), .dval_in(dv), .test_en(tm),
      .mem_clk(mclk), .mem_rst(mrst), .slot_in(slot), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .ovf(ovf)
   );

   always #2 mclk = ~mclk;
   initial begin
      #1;
      forever #6 cclk = ~cclk;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // slot counter driven after each memory edge
   initial forever begin
      @(posedge mclk);
      #1;
      slot = block ? 2'd0 : slot + 2'd1;
   end

   // per-clock comparison against the expected-word queue
   initial forever begin
      @(negedge mclk);
      if (!mrst) begin
         cyc++;
         if (wr_en) begin
            check(slot == 2'd2, "R5 slot", 64'(slot), 64'd2);
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected write", 64'(wr_addr), 64'd0);
            end else begin
               check(wr_addr == exp_q[0][54:36], {tag, " addr R2"}, 64'(wr_addr), 64'(exp_q[0][54:36]));
               check(wr_data == exp_q[0][35:0], {tag, " data R1"}, 64'(wr_data), 64'(exp_q[0][35:0]));
               void'(exp_q.pop_front());
               void'(t_q.pop_front());
            end
         end
         if (!block && t_q.size() > 0 && (cyc - t_q[0]) > 14) begin
            check(1'b0, "R6 latency", 64'(cyc - t_q[0]), 64'd14);
            void'(exp_q.pop_front());
            void'(t_q.pop_front());
         end
      end
   end

   always @(posedge mclk) begin
      wd++;
      if (wd > 100000) begin
         check(1'b0, "watchdog", 64'(wd), 64'd100000);
         summary();
      end
   end

   // one capture cycle: drive inputs and advance the behavioural model
   task automatic cap(input bit h, input bit v, input bit f, input bit d, input int l, input bit t);
      logic [7:0] p;
      @(negedge cclk);
      hsy = h; vsy = v; fld = f; dv = d; luma = 10'(l); tm = t;
      if (v) m_line = 0;
      else if (h && !m_hprev) m_line = m_line + 1;
      m_hprev = h;
      if (h || v) begin
         m_col = 0;
         m_buf = '0;
      end else if (d) begin
         p = t ? 8'(m_col % 256) : 8'(l >> 2);
         m_buf = {m_buf[23:0], p};
         if (m_col % 4 == 3) begin
            exp_q.push_back({1'b0, 9'(m_line), f, 8'(m_col / 4), 4'h0, m_buf});
            t_q.push_back(cyc);
         end
         m_col = (m_col + 1) % 1024;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cap(0, 0, fld, 0, 0, 0);
   endtask

   initial begin
      repeat (6) @(negedge cclk);
      crst = 1'b0; mrst = 1'b0;
      @(negedge mclk);
      check(wr_en == 1'b0, "R10 wr_en after reset", 64'(wr_en), 64'd0);
      check(ovf == 1'b0, "R10 ovf after reset", 64'(ovf), 64'd0);

      // R1 R2 R10: first line, eight pixels
      tag = "R10";
      for (int i = 0; i < 8; i++) cap(0, 0, 0, 1, i * 37 + 5, 0);
      idle(10);

      // R3: invalid samples and samples during sync are skipped
      tag = "R3";
      for (int i = 0; i < 8; i++) begin
         cap(0, 0, 0, 1, 900 - i * 9, 0);
         cap(0, 0, 0, 0, 1023, 0);
      end
      idle(10);

      // R4: partial group discarded, line advances on each hsync
      tag = "R4";
      cap(1, 0, 0, 1, 111, 0);
      cap(1, 0, 0, 0, 0, 0);
      cap(0, 0, 1, 1, 222, 0);
      cap(0, 0, 1, 1, 333, 0);
      cap(1, 0, 1, 0, 0, 0);
      for (int i = 0; i < 4; i++) cap(0, 0, 1, 1, 512 + i * 100, 0);
      idle(10);

      // R4: vertical sync returns to line 0; odd field row
      tag = "R4 vsync";
      cap(0, 1, 1, 1, 0, 0);
      cap(1, 1, 1, 0, 0, 0);
      for (int i = 0; i < 4; i++) cap(0, 0, 1, 1, 64 + i, 0);
      idle(10);

      // R9: test pattern
      tag = "R9";
      for (int i = 0; i < 8; i++) cap(0, 0, 1, 1, 1023, 1);
      idle(10);
      check(exp_q.size() == 0, "R6 drained", 64'(exp_q.size()), 64'd0);
      check(ovf == 1'b0, "R8 no overflow yet", 64'(ovf), 64'd0);

      // R8 R7: block the slot, three words arrive, the last survives
      tag = "R8";
      block = 1'b1;
      for (int w = 0; w < 3; w++) begin
         for (int i = 0; i < 4; i++) cap(0, 0, 0, 1, 100 * w + 17 * i, 0);
         idle(4);
      end
      idle(6);
      check(ovf == 1'b1, "R8 ovf set", 64'(ovf), 64'd1);
      check(wr_en == 1'b0, "R7 no write while blocked", 64'(wr_en), 64'd0);
      while (exp_q.size() > 1) begin
         void'(exp_q.pop_front());
         void'(t_q.pop_front());
      end
      @(negedge mclk);
      t_q[0] = cyc;
      block = 1'b0;
      idle(10);
      check(exp_q.size() == 0, "R8 survivor written", 64'(exp_q.size()), 64'd0);
      check(ovf == 1'b1, "R8 ovf sticky", 64'(ovf), 64'd1);

      // R10: reset clears overflow and position
      crst = 1'b1; mrst = 1'b1;
      m_col = 0; m_line = 0; m_hprev = 0; m_buf = '0;
      repeat (3) @(negedge cclk);
      crst = 1'b0; mrst = 1'b0;
      @(negedge mclk);
      check(ovf == 1'b0, "R10 ovf cleared", 64'(ovf), 64'd0);
      tag = "R10 after reset";
      for (int i = 0; i < 4; i++) cap(0, 0, 0, 1, 800 + i, 0);
      idle(10);
      check(exp_q.size() == 0, "R6 final drain", 64'(exp_q.size()), 64'd0);
      summary();
   end
endmodule